// File: doc/BRIEF.md
# Streaming Hamming Parity Generator

This block builds the check bits of a single-error-correcting, double-error-detecting Hamming code over a data block that arrives one 32-bit word per cycle. Each bit of the block has a 16-bit index: the word's position in the stream forms the upper 11 bits, and the bit lane inside the word forms the lower 5. For every index bit position the block keeps the even parity of all data bits whose index has a zero in that position. It also keeps the parity of the whole block.

The datapath only accumulates the zero-side group parities and the overall parity. The one-side group parities are derived from them: each is the zero-side parity XORed with the overall parity. Together these form a syndrome source for single-bit correction and two-bit detection. A user pulses start to clear the engine, streams words with valid, and pulses end. The results then freeze behind a done flag until the next start. Blocks longer than 2^16 bits must be split by the user. Words beyond that limit are dropped and flagged.

Top module: `hamming_parity_gen`

## Requirements
- R1: After reset every output is 0: even_par_o, odd_par_o, total_par_o, done_o and overflow_o.
- R2: even_par_o[p] is the XOR of every accepted data bit whose 16-bit index has bit p equal to 0. The index is (words accepted before this word) * 32 + lane, so lane = bits [4:0] and word count = bits [15:5].
- R3: total_par_o is the XOR of every accepted data bit.
- R4: odd_par_o equals even_par_o XOR {16{total_par_o}}. It is the inverse of even_par_o when the overall parity is 1 and equal to it when the overall parity is 0.
- R5: done_o is 1 in the cycle after end_i is sampled. While done_o is 1, valid words are ignored and all parity outputs hold their values until the next start.
- R6: start_i clears the parities, the word count, done_o and overflow_o in the next cycle. It takes priority over valid_i and end_i in the same cycle.
- R7: At most 2048 words are accepted per block. A valid word arriving after that is ignored and sets overflow_o, which stays 1 until start or reset.
- R8: A valid word presented in the same cycle as end_i is included in the results.
- R9: An accepted word's effect appears on the outputs in the cycle after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Clear pulse that begins a new block |
| valid_i | input | 1 | data_i holds a word this cycle |
| data_i | input | 32 | Data word; bit n is lane n |
| end_i | input | 1 | Last-word marker; freezes the results |
| even_par_o | output | 16 | Zero-side group parities, one per index bit |
| odd_par_o | output | 16 | One-side group parities |
| total_par_o | output | 1 | Parity of the whole block |
| done_o | output | 1 | Results are final |
| overflow_o | output | 1 | A word beyond 2048 was dropped |

## Verification
The bench drives single-bit words at index 0 and at the last index 65535.

- At index 0 every zero-side parity must be set. A design with the lanes or word bits reversed, or with the masks inverted, fails here.
- At index 65535 only the overall parity and the one-side group are set, which exposes a derived parity with the wrong sign.

It then streams exactly 2048 words plus extra ones. A counter that is off by one either drops the last legal word or folds a wrapped address into the parities.

It also presses start together with valid, and valid together with end. A design with the wrong priority keeps stale parity in the first case or drops the final word in the second. Words sent after done catch a design that keeps accumulating once the results are frozen.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
    parameter int WORD_W   = 32;
    parameter int BLK_LOG2 = 16;

    localparam int OFS_W     = $clog2(WORD_W);
    localparam int ADDR_W    = BLK_LOG2 - OFS_W;
    localparam int PAR_W     = BLK_LOG2;
    localparam int CNT_W     = ADDR_W + 1;
    localparam int MAX_WORDS = 1 << ADDR_W;

    typedef struct packed {
        logic [PAR_W-1:0] even;
        logic             total;
    } par_acc_t;

    // Lanes whose offset has bit j equal to zero
    function automatic logic [WORD_W-1:0] lane_mask(input int j);
        logic [WORD_W-1:0] m;
        for (int b = 0; b < WORD_W; b++) begin
            m[b] = ((b >> j) & 1) == 0;
        end
        return m;
    endfunction
endpackage

// File: rtl/hecc_word_par.sv
module hecc_word_par
    import hecc_pkg::*;
(
    input  logic [WORD_W-1:0] data_i,
    output logic [OFS_W-1:0]  low_par_o,
    output logic              word_par_o
);
    for (genvar j = 0; j < OFS_W; j++) begin : g_low
        assign low_par_o[j] = ^(data_i & lane_mask(j));
    end
    assign word_par_o = ^data_i;
endmodule

// File: rtl/hecc_ctrl.sv
module hecc_ctrl
    import hecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              valid_i,
    input  logic              end_i,
    output logic              accept_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o,
    output logic              overflow_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             full;

    assign full     = cnt_q[CNT_W-1];
    assign addr_o   = cnt_q[ADDR_W-1:0];
    assign accept_o = valid_i && !done_o && !full && !start_i;

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            cnt_q      <= '0;
            done_o     <= 1'b0;
            overflow_o <= 1'b0;
        end else begin
            if (valid_i && !done_o) begin
                if (!full) cnt_q <= cnt_q + 1'b1;
                else       overflow_o <= 1'b1;
            end
            if (end_i) done_o <= 1'b1;
        end
    end
endmodule

// File: rtl/hecc_accum.sv
module hecc_accum
    import hecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [OFS_W-1:0]  low_par_i,
    input  logic              word_par_i,
    output par_acc_t          acc_o
);
    par_acc_t nxt;

    assign nxt.even[OFS_W-1:0] = acc_o.even[OFS_W-1:0] ^ low_par_i;
    for (genvar k = 0; k < ADDR_W; k++) begin : g_high
        assign nxt.even[OFS_W+k] = acc_o.even[OFS_W+k] ^ (word_par_i & ~addr_i[k]);
    end
    assign nxt.total = acc_o.total ^ word_par_i;

    always_ff @(posedge clk) begin
        if (rst || clear_i) acc_o <= '0;
        else if (accept_i)  acc_o <= nxt;
    end
endmodule

// File: rtl/hamming_parity_gen.sv
module hamming_parity_gen
    import hecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              valid_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              end_i,
    output logic [PAR_W-1:0]  even_par_o,
    output logic [PAR_W-1:0]  odd_par_o,
    output logic              total_par_o,
    output logic              done_o,
    output logic              overflow_o
);
    logic [OFS_W-1:0]  low_par;
    logic              word_par;
    logic              accept;
    logic [ADDR_W-1:0] addr;
    par_acc_t          acc;

    hecc_word_par u_wp (
        .data_i     (data_i),
        .low_par_o  (low_par),
        .word_par_o (word_par)
    );

    hecc_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .valid_i    (valid_i),
        .end_i      (end_i),
        .accept_o   (accept),
        .addr_o     (addr),
        .done_o     (done_o),
        .overflow_o (overflow_o)
    );

    hecc_accum u_acc (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (start_i),
        .accept_i   (accept),
        .addr_i     (addr),
        .low_par_i  (low_par),
        .word_par_i (word_par),
        .acc_o      (acc)
    );

    assign even_par_o  = acc.even;
    assign total_par_o = acc.total;
    for (genvar p = 0; p < PAR_W; p++) begin : g_odd
        assign odd_par_o[p] = acc.even[p] ^ acc.total;
    end
endmodule

// File: rtl/hecc_chk.sv
module hecc_chk
    import hecc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             valid_i,
    input logic             end_i,
    input logic [PAR_W-1:0] even_par_o,
    input logic             total_par_o,
    input logic             done_o,
    input logic             overflow_o
);
    // R5
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (end_i && !start_i) |=> done_o);
    // R5
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> ($stable(even_par_o) && $stable(total_par_o) && done_o));
    // R6
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (even_par_o == '0 && !total_par_o && !done_o && !overflow_o));
    // R7
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overflow_o && !start_i) |=> overflow_o);
    // R3
    idle_total_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid_i && !start_i) |=> ($stable(total_par_o) && $stable(even_par_o)));
endmodule

bind hamming_parity_gen hecc_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .valid_i     (valid_i),
    .end_i       (end_i),
    .even_par_o  (even_par_o),
    .total_par_o (total_par_o),
    .done_o      (done_o),
    .overflow_o  (overflow_o)
);

// File: tb/hamming_parity_gen_tb.sv
module hamming_parity_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] data_i = '0;
    logic        end_i = 1'b0;
    logic [15:0] even_par_o, odd_par_o;
    logic        total_par_o, done_o, overflow_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit live = 1'b0;

    // behavioural reference
    logic [15:0] m_even = '0;
    logic        m_tot = 1'b0;
    int          m_cnt = 0;
    logic        m_done = 1'b0;
    logic        m_ovf = 1'b0;

    always #2 clk = ~clk;

    hamming_parity_gen u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .valid_i(valid_i),
        .data_i(data_i), .end_i(end_i), .even_par_o(even_par_o),
        .odd_par_o(odd_par_o), .total_par_o(total_par_o),
        .done_o(done_o), .overflow_o(overflow_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst || start_i) begin
            m_even = '0; m_tot = 1'b0; m_cnt = 0; m_done = 1'b0; m_ovf = 1'b0;
        end else begin
            if (valid_i && !m_done) begin
                if (m_cnt < 2048) begin
                    for (int b = 0; b < 32; b++) begin
                        if (data_i[b]) begin
                            int idx;
                            idx = m_cnt * 32 + b;
                            m_tot = ~m_tot;
                            for (int p = 0; p < 16; p++)
                                if (((idx >> p) & 1) == 0) m_even[p] = ~m_even[p];
                        end
                    end
                    m_cnt++;
                end else m_ovf = 1'b1;
            end
            if (end_i) m_done = 1'b1;
        end
        live = 1'b1;
    end

    // per-cycle comparison against the model (R9 latency implied)
    always @(negedge clk) begin
        if (live) begin
            check("R2 even", {16'h0, even_par_o}, {16'h0, m_even});
            check("R4 odd", {16'h0, odd_par_o}, {16'h0, m_even ^ {16{m_tot}}});
            check("R3 total", {31'h0, total_par_o}, {31'h0, m_tot});
            check("R5 done", {31'h0, done_o}, {31'h0, m_done});
            check("R7 overflow", {31'h0, overflow_o}, {31'h0, m_ovf});
        end
    end

    task automatic cyc(input logic s, input logic v, input logic [31:0] d, input logic e);
        start_i = s; valid_i = v; data_i = d; end_i = e;
        @(negedge clk);
        start_i = 1'b0; valid_i = 1'b0; data_i = '0; end_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [15:0] snap;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 even", {16'h0, even_par_o}, 32'h0);
        check("R1 flags", {29'h0, total_par_o, done_o, overflow_o}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // single bit at index 0: all zero-side groups set
        cyc(1, 0, 0, 0);
        cyc(0, 1, 32'h1, 1);
        check("R2 idx0 even", {16'h0, even_par_o}, 32'h0000_FFFF);
        check("R4 idx0 odd", {16'h0, odd_par_o}, 32'h0);
        check("R8 end with valid done", {31'h0, done_o}, 32'h1);
        // R5: words after done are ignored
        snap = even_par_o;
        cyc(0, 1, 32'hFFFF_0001, 0);
        cyc(0, 1, 32'h8000_0000, 0);
        check("R5 frozen", {16'h0, even_par_o}, {16'h0, snap});

        // R6: start beats valid in the same cycle
        cyc(1, 1, 32'hDEAD_BEEF, 1);
        check("R6 cleared", {16'h0, even_par_o}, 32'h0);
        check("R6 flags", {29'h0, total_par_o, done_o, overflow_o}, 32'h0);

        // random block, last word carries bit 31 at index 65535
        for (int w = 0; w < 2047; w++) cyc(0, (w % 7) != 3, $urandom, 0);
        cyc(1, 0, 0, 0);
        for (int w = 0; w < 2047; w++) cyc(0, 1, 32'h0, 0);
        cyc(0, 1, 32'h8000_0000, 0);
        check("R2 idx65535 even", {16'h0, even_par_o}, 32'h0);
        check("R4 idx65535 odd", {16'h0, odd_par_o}, 32'h0000_FFFF);
        check("R7 no overflow at limit", {31'h0, overflow_o}, 32'h0);
        // R7: one more word is dropped
        cyc(0, 1, 32'h0000_0001, 0);
        check("R7 overflow set", {31'h0, overflow_o}, 32'h1);
        check("R7 word dropped", {31'h0, total_par_o}, 32'h1);
        cyc(0, 0, 0, 1);
        check("R5 done after end", {31'h0, done_o}, 32'h1);

        // random short blocks, two-bit patterns
        for (int blk = 0; blk < 4; blk++) begin
            cyc(1, 0, 0, 0);
            for (int w = 0; w < 40; w++) cyc(0, $urandom_range(0, 1), $urandom, 0);
            cyc(0, 1, 32'h0000_0011, 1);
            repeat (2) @(negedge clk);
        end
        finish_run();
    end
endmodule